// File: doc/BRIEF.md
# Programmable-Width Synchronous Serial Master

This block is the serial engine of a master-mode synchronous serial port. It takes words one at a time from an external transmit buffer and shifts them out most-significant bit first on a data-out pin. At the same time it shifts in the same number of bits from a data-in pin and hands each received word to an external receive buffer. A run-time control word selects the frame length (4 to 16 bits), the frame format, the source of the reference clock and an 8-bit divisor, and turns the port on or off.

The serial clock idles low. Select goes low at the start of a frame and stays low until the frame ends. The engine changes data out on each falling serial-clock edge and samples data in on each rising edge. A serial-clock half period lasts divisor+1 reference ticks. A reference tick is either every system clock cycle or one synchronized rising edge of an external reference input. The control word is captured when a frame starts, so a change made during a frame applies from the next frame.

A state machine with three states controls the engine. IDLE waits for a start. The start transition IDLE→SHIFT needs the port enabled, a word waiting and a valid configuration; on it the engine captures the configuration and takes the word. SHIFT toggles the serial clock on each half-period tick. The last-bit transition SHIFT→FINISH happens on the falling edge that ends bit N. The abort transition SHIFT→IDLE happens when the port is disabled. FINISH delivers the received word, and FINISH→IDLE is taken unconditionally on the next cycle.

Top module: `sspw_master`

## Requirements
- R1: A size code S from 3 to 15 gives a frame of N = S+1 bits: exactly N rising edges of `sclk` while `sel_n` is low.
- R2: Size codes 0, 1 and 2 are invalid. While the port is enabled with such a code, `cfg_err` is 1 (two cycles after the code is applied), no word is taken (`tx_pop` stays 0) and `sel_n` stays 1.
- R3: The received word is right-justified. Bits N-1..0 of `rx_data` hold the received bits, with the first received bit in bit N-1, and bits 15..N are 0.
- R4: Only bits N-1..0 of `tx_data` are sent, starting with bit N-1. Bits 15..N have no effect on `mosi`.
- R5: With `cfg_extsel`=0, one `sclk` period lasts 2×(D+1) system clock cycles, where D is `cfg_div`.
- R6: With `cfg_extsel`=1, one `sclk` period lasts 2×(D+1) rising edges of `ext_ref`, after those edges are synchronized into the system clock domain.
- R7: With `cfg_en`=0, no frame starts, `pins_oe` is 0, `sclk` is 0 and `sel_n` is 1. Clearing `cfg_en` during a frame ends it with `sel_n` high and no `rx_push`.
- R8: Format code 2'b11 is invalid: `cfg_err` is 1 and no frame starts. Codes 2'b00, 2'b01 and 2'b10 are accepted, and frames run with the signalling of R9.
- R9: `sclk` idles low and `sel_n` is low for the whole frame. `mosi` changes after a falling `sclk` edge, and `miso` is sampled on the rising edge.
- R10: A frame starts only when `cfg_en`=1, `tx_valid`=1 and the configuration is valid. `tx_pop` pulses for one cycle at the start. At the end, `rx_push` pulses for exactly one cycle, with `rx_data` valid during that cycle.
- R11: A change to `cfg_size` or `cfg_div` while a frame is in progress does not alter that frame's length or bit rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_en | input | 1 | Port enable |
| cfg_size | input | 4 | Frame size code (N = code+1) |
| cfg_fmt | input | 2 | Frame format code |
| cfg_extsel | input | 1 | 0 = system clock reference, 1 = external reference |
| cfg_div | input | 8 | Clock rate divisor D |
| ext_ref | input | 1 | External reference, asynchronous |
| tx_valid | input | 1 | Transmit buffer holds a word |
| tx_data | input | 16 | Word at the head of the transmit buffer |
| tx_pop | output | 1 | One-cycle pulse: word taken |
| rx_data | output | 16 | Last received word, right-justified |
| rx_push | output | 1 | One-cycle pulse: frame done, rx_data valid |
| cfg_err | output | 1 | Invalid size or format while enabled |
| pins_oe | output | 1 | Serial pins driven (0 = released) |
| sclk | output | 1 | Serial clock |
| sel_n | output | 1 | Frame select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench runs frames at the shortest length (4 bits) and the longest (16 bits) with garbage in the unused upper transmit bits. An engine that misplaced the bit index would send the wrong bits or count the wrong number of clock edges, and one that failed to zero-fill would return nonzero upper receive bits. The serial clock period is timed at divisor 0 and at nonzero divisors, and with the external reference, so an off-by-one in the divider shows up as a wrong period. The bench also tests reserved size and format codes, disabling the port mid-frame, and changing the configuration mid-frame. A design that started on a bad code would take a word, one that did not abort would still pulse done, and one that did not capture its configuration at the start would change the frame length or rate part way through.

// File: rtl/sspw_pkg.sv
package sspw_pkg;
    // Smallest size code that selects a real frame (4 bits).
    localparam int SSPW_MIN_CODE = 3;
    // Reserved frame format code.
    localparam logic [1:0] SSPW_FMT_RSVD = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } sspw_state_e;
endpackage

// File: rtl/sspw_refsync.sv
module sspw_refsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_ref,
    input  logic sel_ext,
    output logic tick
);
    // chain[STAGES-1] is the synchronized level; chain[STAGES] is its delayed copy.
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], ext_ref};
        end
    end

    assign tick = sel_ext ? (chain[STAGES-1] & ~chain[STAGES]) : 1'b1;

    // A synchronized rising edge cannot yield ticks on two cycles in a row.
    p_ext_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ext && tick) |=> (!tick || !sel_ext));
endmodule

// File: rtl/sspw_baudgen.sv
module sspw_baudgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ref_tick,
    input  logic [DIV_W-1:0] div,
    output logic             half_tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            half_tick <= 1'b0;
        end else if (!run) begin
            cnt       <= '0;
            half_tick <= 1'b0;
        end else if (ref_tick) begin
            if (cnt == div) begin
                cnt       <= '0;
                half_tick <= 1'b1;
            end else begin
                cnt       <= cnt + 1'b1;
                half_tick <= 1'b0;
            end
        end else begin
            half_tick <= 1'b0;
        end
    end

    // The counter never passes the divisor while a frame runs.
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= div));
endmodule

// File: rtl/sspw_engine.sv
module sspw_engine
    import sspw_pkg::*;
#(
    parameter int MAX_W  = 16,
    parameter int CODE_W = 4,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [CODE_W-1:0] cfg_size,
    input  logic [1:0]        cfg_fmt,
    input  logic              cfg_extsel,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_valid,
    input  logic [MAX_W-1:0]  tx_data,
    input  logic              half_tick,
    input  logic              miso,
    output logic              run,
    output logic              lat_ext,
    output logic [DIV_W-1:0]  lat_div,
    output logic              tx_pop,
    output logic [MAX_W-1:0]  rx_data,
    output logic              rx_push,
    output logic              cfg_err,
    output logic              pins_oe,
    output logic              sclk,
    output logic              sel_n,
    output logic              mosi
);
    localparam logic [MAX_W-1:0] ALL_ONES = '1;

    sspw_state_e       state, state_nx;
    logic [CODE_W-1:0] lat_size;
    logic [CODE_W-1:0] bitcnt;
    logic [MAX_W-1:0]  tx_sh;
    logic [MAX_W-1:0]  rx_sh;
    logic              sclk_q;
    logic              sel_q;
    logic              cfg_ok;
    logic              go;
    logic              last_fall;

    assign cfg_ok    = (cfg_size >= CODE_W'(SSPW_MIN_CODE)) && (cfg_fmt != SSPW_FMT_RSVD);
    assign go        = cfg_en && tx_valid && cfg_ok;
    assign last_fall = half_tick && sclk_q && (bitcnt == lat_size);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: start, last-bit, abort, finish
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (go) state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!cfg_en)        state_nx = ST_IDLE;
                else if (last_fall) state_nx = ST_FINISH;
            end
            ST_FINISH: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_size <= CODE_W'(SSPW_MIN_CODE);
            lat_ext  <= 1'b0;
            lat_div  <= '0;
            bitcnt   <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_data  <= '0;
            sclk_q   <= 1'b0;
            sel_q    <= 1'b1;
            tx_pop   <= 1'b0;
            rx_push  <= 1'b0;
            cfg_err  <= 1'b0;
        end else begin
            tx_pop  <= 1'b0;
            rx_push <= 1'b0;
            cfg_err <= cfg_en && !cfg_ok;
            unique case (state)
                ST_IDLE: begin
                    sclk_q <= 1'b0;
                    if (go) begin
                        lat_size <= cfg_size;
                        lat_ext  <= cfg_extsel;
                        lat_div  <= cfg_div;
                        tx_sh    <= tx_data;
                        rx_sh    <= '0;
                        bitcnt   <= '0;
                        tx_pop   <= 1'b1;
                        sel_q    <= 1'b0;
                    end else begin
                        sel_q <= 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (!cfg_en) begin
                        sclk_q <= 1'b0;
                        sel_q  <= 1'b1;
                    end else if (half_tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            rx_sh  <= {rx_sh[MAX_W-2:0], miso};
                        end else begin
                            sclk_q <= 1'b0;
                            if (bitcnt != lat_size) begin
                                bitcnt <= bitcnt + 1'b1;
                                tx_sh  <= tx_sh << 1;
                            end
                        end
                    end
                end
                ST_FINISH: begin
                    sel_q   <= 1'b1;
                    rx_data <= rx_sh;
                    rx_push <= 1'b1;
                end
                default: begin
                    sclk_q <= 1'b0;
                    sel_q  <= 1'b1;
                end
            endcase
        end
    end

    assign run     = (state == ST_SHIFT);
    assign sclk    = sclk_q;
    assign sel_n   = sel_q;
    assign mosi    = (state == ST_SHIFT) ? tx_sh[lat_size] : 1'b0;
    assign pins_oe = cfg_en;

    p_no_start_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cfg_ok) |=> !tx_pop);

    p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> ((rx_data & ~(ALL_ONES >> (MAX_W - 1 - int'(lat_size)))) == '0));

    p_disabled_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (state == ST_IDLE && !tx_pop));

    p_sel_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> !sel_n);

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);

    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |=> ($stable(lat_size) && $stable(lat_div)));
endmodule

// File: rtl/sspw_master.sv
module sspw_master #(
    parameter int MAX_W       = 16,
    parameter int CODE_W      = 4,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [CODE_W-1:0] cfg_size,
    input  logic [1:0]        cfg_fmt,
    input  logic              cfg_extsel,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              ext_ref,
    input  logic              tx_valid,
    input  logic [MAX_W-1:0]  tx_data,
    output logic              tx_pop,
    output logic [MAX_W-1:0]  rx_data,
    output logic              rx_push,
    output logic              cfg_err,
    output logic              pins_oe,
    output logic              sclk,
    output logic              sel_n,
    output logic              mosi,
    input  logic              miso
);
    logic             ref_tick;
    logic             half_tick;
    logic             run;
    logic             lat_ext;
    logic [DIV_W-1:0] lat_div;

    sspw_refsync #(.STAGES(SYNC_STAGES)) u_refsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_ref (ext_ref),
        .sel_ext (lat_ext),
        .tick    (ref_tick)
    );

    sspw_baudgen #(.DIV_W(DIV_W)) u_baudgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .ref_tick  (ref_tick),
        .div       (lat_div),
        .half_tick (half_tick)
    );

    sspw_engine #(.MAX_W(MAX_W), .CODE_W(CODE_W), .DIV_W(DIV_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_en),
        .cfg_size   (cfg_size),
        .cfg_fmt    (cfg_fmt),
        .cfg_extsel (cfg_extsel),
        .cfg_div    (cfg_div),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .half_tick  (half_tick),
        .miso       (miso),
        .run        (run),
        .lat_ext    (lat_ext),
        .lat_div    (lat_div),
        .tx_pop     (tx_pop),
        .rx_data    (rx_data),
        .rx_push    (rx_push),
        .cfg_err    (cfg_err),
        .pins_oe    (pins_oe),
        .sclk       (sclk),
        .sel_n      (sel_n),
        .mosi       (mosi)
    );
endmodule

// File: tb/sspw_master_tb.sv
`timescale 1ns/1ps
module sspw_master_tb_top;
    localparam int EXT_P = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic [3:0]  cfg_size = 4'd7;
    logic [1:0]  cfg_fmt = 2'b00;
    logic        cfg_extsel = 1'b0;
    logic [7:0]  cfg_div = 8'd0;
    logic        ext_ref = 1'b0;
    logic        tx_valid = 1'b0;
    logic [15:0] tx_data = 16'h0;
    logic        tx_pop, rx_push, cfg_err, pins_oe, sclk, sel_n, mosi, miso;
    logic [15:0] rx_data;

    int n_chk = 0;
    int n_fail = 0;

    // Slave model state (set by tasks) and observation counters (set by always blocks)
    logic [15:0] slv_word = 16'h0;
    int          slv_n = 0;
    int          rise_base = 0;
    int          rises_tot = 0;
    int          pops_tot = 0;
    int          pushes_tot = 0;
    int          ext_cnt = 0;
    logic [15:0] cap = 16'h0;
    realtime     t_prev = 0.0;
    realtime     t_last = 0.0;

    always #2.5 clk = ~clk;

    sspw_master dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_size(cfg_size),
        .cfg_fmt(cfg_fmt), .cfg_extsel(cfg_extsel), .cfg_div(cfg_div),
        .ext_ref(ext_ref), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push),
        .cfg_err(cfg_err), .pins_oe(pins_oe), .sclk(sclk), .sel_n(sel_n),
        .mosi(mosi), .miso(miso)
    );

    // External reference: rising edge every EXT_P clock cycles
    always @(negedge clk) begin
        if (ext_cnt == EXT_P/2 - 1) begin
            ext_cnt <= 0;
            ext_ref <= ~ext_ref;
        end else begin
            ext_cnt <= ext_cnt + 1;
        end
    end

    // Slave: presents bit (N-1-k) after k rising edges of the frame
    int idx;
    assign idx  = rises_tot - rise_base;
    assign miso = (idx >= 0 && idx < slv_n) ? slv_word[slv_n-1-idx] : 1'b0;

    always @(posedge sclk) begin
        cap       <= {cap[14:0], mosi};
        rises_tot <= rises_tot + 1;
        t_prev    <= t_last;
        t_last    <= $realtime;
    end

    always @(posedge clk) begin
        if (tx_pop)  pops_tot   <= pops_tot + 1;
        if (rx_push) pushes_tot <= pushes_tot + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sel_n == 1'b1 && sclk == 1'b0, "R9 reset idle pins", {sel_n, sclk}, 2'b10);
        check(tx_pop == 1'b0 && rx_push == 1'b0, "R10 reset pulses low", {tx_pop, rx_push}, 0);
        check(cfg_err == 1'b0 && pins_oe == 1'b0, "R7 reset disabled", {cfg_err, pins_oe}, 0);
    endtask

    task automatic t_no_data();
        int p0;
        @(negedge clk);
        cfg_en = 1'b1; cfg_size = 4'd7; cfg_fmt = 2'b00; tx_valid = 1'b0;
        p0 = pops_tot;
        repeat (20) @(negedge clk);
        check(pops_tot == p0 && sel_n == 1'b1, "R10 no start when buffer empty", pops_tot - p0, 0);
        check(pins_oe == 1'b1, "R7 pins driven when enabled", pins_oe, 1);
    endtask

    task automatic run_frame(input string tag, input logic [3:0] sz, input logic [7:0] dv,
                             input logic [1:0] fm, input bit ex, input logic [15:0] txw,
                             input logic [15:0] slw, input bit change_mid);
        int n, t, p0, u0, per, exp_per;
        logic [15:0] mask, got;
        bit popped;
        n = int'(sz) + 1;
        mask = 16'((32'd1 << n) - 1);
        @(negedge clk);
        cfg_en = 1'b1; cfg_size = sz; cfg_div = dv; cfg_fmt = fm; cfg_extsel = ex;
        slv_word = slw; slv_n = n; rise_base = rises_tot;
        p0 = pops_tot; u0 = pushes_tot;
        tx_data = txw; tx_valid = 1'b1;
        t = 0;
        while (!tx_pop && t < 100) begin @(negedge clk); t++; end
        popped = tx_pop;
        tx_valid = 1'b0;
        if (change_mid) begin cfg_size = 4'd15; cfg_div = 8'd0; end
        t = 0;
        while (!rx_push && t < 3000) begin @(negedge clk); t++; end
        got = rx_data;
        check(rx_push == 1'b1, {tag, " R10 done pulse seen"}, rx_push, 1);
        repeat (3) @(negedge clk);
        check(popped && pops_tot - p0 == 1, {tag, " R10 one word taken"}, pops_tot - p0, 1);
        check(pushes_tot - u0 == 1, {tag, " R10 done lasts one cycle"}, pushes_tot - u0, 1);
        check(rises_tot - rise_base == n, {tag, " R1 R11 rising edges per frame"}, rises_tot - rise_base, n);
        check((cap & mask) == (txw & mask), {tag, " R4 R9 serial data out"}, cap & mask, txw & mask);
        check(got == (slw & mask), {tag, " R3 right-justified zero-filled"}, got, slw & mask);
        per = int'(t_last - t_prev);
        exp_per = 2 * (int'(dv) + 1) * (ex ? EXT_P : 1) * 5;
        if (ex) check(per == exp_per, {tag, " R6 external period"}, per, exp_per);
        else    check(per == exp_per, {tag, " R5 R11 internal period"}, per, exp_per);
        check(sel_n == 1'b1 && sclk == 1'b0, {tag, " R9 idle after frame"}, {sel_n, sclk}, 2'b10);
    endtask

    task automatic t_bad_size();
        int p0;
        @(negedge clk);
        cfg_en = 1'b1; cfg_size = 4'd2; cfg_fmt = 2'b00; tx_valid = 1'b1;
        p0 = pops_tot;
        repeat (2) @(negedge clk);
        check(cfg_err == 1'b1, "R2 size code 2 flagged", cfg_err, 1);
        cfg_size = 4'd0;
        repeat (40) @(negedge clk);
        check(cfg_err == 1'b1, "R2 size code 0 flagged", cfg_err, 1);
        check(pops_tot == p0 && sel_n == 1'b1, "R2 no start on reserved size", pops_tot - p0, 0);
        tx_valid = 1'b0;
        cfg_size = 4'd7;
        repeat (2) @(negedge clk);
        check(cfg_err == 1'b0, "R2 flag clears on valid size", cfg_err, 0);
    endtask

    task automatic t_bad_fmt();
        int p0;
        @(negedge clk);
        cfg_en = 1'b1; cfg_size = 4'd7; cfg_fmt = 2'b11; tx_valid = 1'b1;
        p0 = pops_tot;
        repeat (40) @(negedge clk);
        check(cfg_err == 1'b1, "R8 reserved format flagged", cfg_err, 1);
        check(pops_tot == p0 && sel_n == 1'b1, "R8 no start on reserved format", pops_tot - p0, 0);
        tx_valid = 1'b0;
        cfg_fmt = 2'b00;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_disabled();
        int p0;
        @(negedge clk);
        cfg_en = 1'b0; cfg_size = 4'd7; cfg_fmt = 2'b00; tx_valid = 1'b1;
        p0 = pops_tot;
        repeat (40) @(negedge clk);
        check(pops_tot == p0, "R7 no start while disabled", pops_tot - p0, 0);
        check(pins_oe == 1'b0 && sel_n == 1'b1 && sclk == 1'b0, "R7 pins released", {pins_oe, sel_n, sclk}, 3'b010);
        tx_valid = 1'b0;
        cfg_en = 1'b1;
    endtask

    task automatic t_abort();
        int t, u0;
        @(negedge clk);
        cfg_en = 1'b1; cfg_size = 4'd15; cfg_div = 8'd10; cfg_fmt = 2'b00; cfg_extsel = 1'b0;
        slv_word = 16'h5555; slv_n = 16; rise_base = rises_tot;
        tx_data = 16'h1234; tx_valid = 1'b1;
        u0 = pushes_tot;
        t = 0;
        while (!tx_pop && t < 100) begin @(negedge clk); t++; end
        tx_valid = 1'b0;
        repeat (60) @(negedge clk);
        check(sel_n == 1'b0, "R9 select low mid-frame", sel_n, 0);
        cfg_en = 1'b0;
        repeat (2) @(negedge clk);
        check(sel_n == 1'b1 && sclk == 1'b0, "R7 abort releases frame", {sel_n, sclk}, 2'b10);
        repeat (400) @(negedge clk);
        check(pushes_tot == u0, "R7 abort gives no done pulse", pushes_tot - u0, 0);
        cfg_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_no_data();
        run_frame("8b", 4'd7, 8'd0, 2'b00, 1'b0, 16'h00A5, 16'h003C, 1'b0);
        run_frame("16b", 4'd15, 8'd3, 2'b00, 1'b0, 16'hBEEF, 16'h1234, 1'b0);
        run_frame("4b", 4'd3, 8'd1, 2'b00, 1'b0, 16'hFFF5, 16'hFFFA, 1'b0);
        run_frame("ext12b", 4'd11, 8'd1, 2'b00, 1'b1, 16'hFABC, 16'hF0F0, 1'b0);
        run_frame("fmt01", 4'd9, 8'd0, 2'b01, 1'b0, 16'h02AA, 16'h0155, 1'b0);
        run_frame("fmt10", 4'd5, 8'd2, 2'b10, 1'b0, 16'hFF2D, 16'h0013, 1'b0);
        t_bad_size();
        t_bad_fmt();
        t_disabled();
        t_abort();
        run_frame("midchg", 4'd7, 8'd2, 2'b00, 1'b0, 16'h00C3, 16'h0081, 1'b1);
        run_frame("after", 4'd15, 8'd0, 2'b00, 1'b0, 16'h8001, 16'h7FFE, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule